// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block collects up to eight interrupt request lines and drives one interrupt output towards a processor. A request line's rising edge is latched into a pending-request register. A mask register can hide any line. Line 0 has the highest priority, and a line can interrupt only when it outranks every request already being serviced. When the processor raises the acknowledge input, the winning request moves from the pending register to the in-service register. One cycle later the block presents a vector byte, which is the programmed base with the line number in its low bits.

Software reaches the block through a byte-wide port with two addresses. Address 0 takes setup-start and operation commands and returns a status byte: the pending register, the in-service register or a poll byte, depending on the last select command. Address 1 takes the remaining setup bytes while setup runs. Outside setup it is the mask register, for both writes and reads. The setup sequence follows the flags in its first byte. Triggering-level and cascade choices, special masking and priority rotation are accepted but have no effect.

Top module: `intc8_core`

## Requirements
- R1: After reset the pending, in-service and mask registers are all zero, `int_out` and `vec_valid` are low, and reads of address 0 return the poll byte, which is 0x00.
- R2: A 0-to-1 transition on a request line sets its pending bit at the next clock edge. A line held high does not set the bit again once it has been cleared.
- R3: A write to address 0 with data bit 4 set starts setup. The next write to address 1 stores the vector base as the data with bits 2:0 cleared. Setup writes leave the mask register unchanged.
- R4: In the setup-start byte, bit 1 = 0 (cascade) inserts one extra address-1 byte after the base byte, and bit 0 = 1 adds one final address-1 byte. After the last expected byte, address-1 writes load the mask again. Bit 3 (level triggering) has no effect, and edge capture stays in force.
- R5: A write to address 0 with bit 4 clear while setup is in progress ends setup at once and is also carried out as a command.
- R6: Outside setup, a write to address 1 loads the mask register (bit n = 1 hides line n). A read of address 1 returns the mask register.
- R7: Command 0x0A makes address-0 reads return the pending register, and command 0x0B makes them return the in-service register. The choice holds until another select command arrives.
- R8: After command 0x0C, and by default from reset, address-0 reads return 0x80 OR the index of the lowest-numbered pending bit, ignoring the mask, or 0x00 when nothing is pending.
- R9: Command 0x20 clears every in-service bit and clears the same bits in the pending register.
- R10: Commands 0x21–0x27, 0x60–0x67 and 0xE0–0xE7 clear the pending bit and the in-service bit whose index is data bits 2:0.
- R11: Other command bytes, including 0x68 and 0xC0–0xC7, change neither register, the mask nor the read selection.
- R12: `int_out` is high exactly when some unmasked pending line has a lower index than every in-service line, or when there is an unmasked pending line and nothing is in service.
- R13: A one-cycle `int_ack` while `int_out` is high moves the winning line from pending to in-service. The next cycle `vec_valid` pulses with `vec_id` equal to base OR index. An acknowledge while `int_out` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Byte write strobe for the register port |
| reg_addr | input | 1 | Register port address (0 command/status, 1 setup/mask) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed location, combinational |
| irq_lines | input | NUM_IRQ | Request lines, captured on rising edges |
| int_ack | input | 1 | Interrupt acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe marking `vec_id` valid |
| vec_id | output | DATA_W | Vector byte for the acknowledged line |

## Verification
The embedded properties assume that the request lines and `int_ack` are synchronous to `clk` and that `int_ack` lasts one cycle. They also assume that a register write and an acknowledge do not occur in the same cycle when an end-of-interrupt clear is being checked. The stimulus changes inputs only on falling clock edges and holds every acknowledge and write strobe for exactly one cycle. It never overlaps an acknowledge with a register write, and it pulses request lines for one cycle, except for one deliberately held line that exercises the no-retrigger rule.

// File: rtl/intc8_pkg.sv
package intc8_pkg;

   typedef enum logic [1:0] {
      SETUP_IDLE = 2'd0,
      SETUP_BASE = 2'd1,
      SETUP_LINK = 2'd2,
      SETUP_MODE = 2'd3
   } setup_state_t;

   typedef enum logic [1:0] {
      RSEL_POLL    = 2'd0,
      RSEL_PENDING = 2'd1,
      RSEL_SERVICE = 2'd2
   } read_sel_t;

   typedef struct packed {
      logic       sel_pending;
      logic       sel_service;
      logic       sel_poll;
      logic       eoi_all;
      logic       eoi_one;
      logic [2:0] eoi_line;
   } cmd_dec_t;

   function automatic logic is_line_eoi(input logic [7:0] code);
      return ((code[7:3] == 5'b00100) && (code[2:0] != 3'd0)) ||
             (code[7:3] == 5'b01100) ||
             (code[7:3] == 5'b11100);
   endfunction

endpackage

// File: rtl/intc8_prio_enc.sv
module intc8_prio_enc #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);

   generate
      if (N < 1) begin : g_bad_n
         $error("intc8_prio_enc: N must be at least 1");
      end
      if ((1 << IW) < N) begin : g_bad_iw
         $error("intc8_prio_enc: IW too narrow for N");
      end
   endgenerate

   // lowest index wins: scan downward so the last hit is the smallest index
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign found = |req;

endmodule

// File: rtl/intc8_cmd_dec.sv
module intc8_cmd_dec (
   input  logic                 [7:0] code,
   output intc8_pkg::cmd_dec_t        dec
);
   import intc8_pkg::*;

   always_comb begin
      dec             = '0;
      dec.sel_pending = (code == 8'h0A);
      dec.sel_service = (code == 8'h0B);
      dec.sel_poll    = (code == 8'h0C);
      dec.eoi_all     = (code == 8'h20);
      dec.eoi_one     = is_line_eoi(code);
      dec.eoi_line    = code[2:0];
   end

endmodule

// File: rtl/intc8_setup_seq.sv
module intc8_setup_seq #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic              cmd_wr,
   input  logic              data_wr,
   input  logic              start_single,
   input  logic              start_want_mode,
   input  logic [DATA_W-4:0] data_hi,
   output logic              busy,
   output logic [DATA_W-1:0] vec_base
);
   import intc8_pkg::*;

   setup_state_t state_q;
   logic         single_q;
   logic         want_mode_q;
   logic [DATA_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= SETUP_IDLE;
         single_q    <= 1'b0;
         want_mode_q <= 1'b0;
         base_q      <= '0;
      end else if (start_wr) begin
         state_q     <= SETUP_BASE;
         single_q    <= start_single;
         want_mode_q <= start_want_mode;
      end else if (cmd_wr) begin
         state_q <= SETUP_IDLE;
      end else if (data_wr) begin
         unique case (state_q)
            SETUP_BASE: begin
               base_q <= {data_hi, 3'b000};
               if (!single_q)        state_q <= SETUP_LINK;
               else if (want_mode_q) state_q <= SETUP_MODE;
               else                  state_q <= SETUP_IDLE;
            end
            SETUP_LINK: state_q <= want_mode_q ? SETUP_MODE : SETUP_IDLE;
            SETUP_MODE: state_q <= SETUP_IDLE;
            default:    state_q <= SETUP_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != SETUP_IDLE);
   assign vec_base = base_q;

   assert_setup_start_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (state_q == SETUP_BASE));

   assert_setup_abort_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy) |=> !busy);

   assert_base_low_clear_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && state_q == SETUP_BASE) |=> (vec_base[2:0] == 3'b000));

endmodule

// File: rtl/intc8_core.sv
module intc8_core #(
   parameter int NUM_IRQ = 8,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_IRQ-1:0] irq_lines,
   input  logic               int_ack,
   output logic               int_out,
   output logic               vec_valid,
   output logic [DATA_W-1:0]  vec_id
);
   import intc8_pkg::*;

   localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("intc8_core: DATA_W must be 8 (byte register port)");
      end
      if (NUM_IRQ < 1 || NUM_IRQ > 8) begin : g_bad_num_irq
         $error("intc8_core: NUM_IRQ must lie in 1..8");
      end
   endgenerate

   // ---------------- register port decode ----------------
   logic wr_cmd_port, wr_data_port, start_wr, cmd_wr, data_wr;
   logic setup_busy;
   logic [DATA_W-1:0] vec_base;
   cmd_dec_t dec;

   assign wr_cmd_port  = reg_wr && !reg_addr;
   assign wr_data_port = reg_wr &&  reg_addr;
   assign start_wr     = wr_cmd_port &&  reg_wdata[4];
   assign cmd_wr       = wr_cmd_port && !reg_wdata[4];
   assign data_wr      = wr_data_port && setup_busy;

   intc8_cmd_dec u_dec (
      .code (reg_wdata),
      .dec  (dec)
   );

   intc8_setup_seq #(.DATA_W(DATA_W)) u_setup (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_wr        (start_wr),
      .cmd_wr          (cmd_wr),
      .data_wr         (data_wr),
      .start_single    (reg_wdata[1]),
      .start_want_mode (reg_wdata[0]),
      .data_hi         (reg_wdata[DATA_W-1:3]),
      .busy            (setup_busy),
      .vec_base        (vec_base)
   );

   // ---------------- state ----------------
   logic [NUM_IRQ-1:0] pend_q, serv_q, mask_q, line_prev_q;
   logic [NUM_IRQ-1:0] rise, pend_clr, serv_clr, serv_set;
   logic [NUM_IRQ-1:0] line_hot, win_hot, live_req;
   read_sel_t          rsel_q;

   // per-line edge detector
   generate
      for (genvar g = 0; g < NUM_IRQ; g++) begin : g_edge
         always_ff @(posedge clk) begin
            if (!rst_n) line_prev_q[g] <= 1'b0;
            else        line_prev_q[g] <= irq_lines[g];
         end
         assign rise[g]     = irq_lines[g] && !line_prev_q[g];
         assign line_hot[g] = (dec.eoi_line == 3'(g));
      end
   endgenerate

   // ---------------- priority resolution ----------------
   logic             req_found, serv_found, raw_found;
   logic [IDX_W-1:0] req_idx, serv_idx, raw_idx;

   assign live_req = pend_q & ~mask_q;

   intc8_prio_enc #(.N(NUM_IRQ), .IW(IDX_W)) u_req_enc (
      .req (live_req), .found (req_found), .idx (req_idx));

   intc8_prio_enc #(.N(NUM_IRQ), .IW(IDX_W)) u_serv_enc (
      .req (serv_q), .found (serv_found), .idx (serv_idx));

   intc8_prio_enc #(.N(NUM_IRQ), .IW(IDX_W)) u_raw_enc (
      .req (pend_q), .found (raw_found), .idx (raw_idx));

   generate
      for (genvar g = 0; g < NUM_IRQ; g++) begin : g_win
         assign win_hot[g] = req_found && (req_idx == IDX_W'(g));
      end
   endgenerate

   assign int_out = req_found && (!serv_found || (req_idx < serv_idx));

   logic ack_fire;
   assign ack_fire = int_ack && int_out;

   // ---------------- register updates ----------------
   always_comb begin
      pend_clr = '0;
      serv_clr = '0;
      if (cmd_wr && dec.eoi_all) begin
         pend_clr = serv_q;
         serv_clr = serv_q;
      end
      if (cmd_wr && dec.eoi_one) begin
         pend_clr = line_hot;
         serv_clr = line_hot;
      end
      if (ack_fire) pend_clr = pend_clr | win_hot;
      serv_set = ack_fire ? win_hot : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         serv_q <= '0;
         mask_q <= '0;
         rsel_q <= RSEL_POLL;
      end else begin
         pend_q <= (pend_q & ~pend_clr) | rise;
         serv_q <= (serv_q & ~serv_clr) | serv_set;
         if (wr_data_port && !setup_busy) mask_q <= reg_wdata[NUM_IRQ-1:0];
         if (cmd_wr && dec.sel_pending)      rsel_q <= RSEL_PENDING;
         else if (cmd_wr && dec.sel_service) rsel_q <= RSEL_SERVICE;
         else if (cmd_wr && dec.sel_poll)    rsel_q <= RSEL_POLL;
      end
   end

   // ---------------- vector output ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_id    <= '0;
      end else begin
         vec_valid <= ack_fire;
         if (ack_fire) vec_id <= vec_base | {{(DATA_W-IDX_W){1'b0}}, req_idx};
      end
   end

   // ---------------- read mux ----------------
   logic [DATA_W-1:0] mask_w, pend_w, serv_w, poll_w;

   generate
      if (NUM_IRQ < DATA_W) begin : g_pad
         assign mask_w = {{(DATA_W-NUM_IRQ){1'b0}}, mask_q};
         assign pend_w = {{(DATA_W-NUM_IRQ){1'b0}}, pend_q};
         assign serv_w = {{(DATA_W-NUM_IRQ){1'b0}}, serv_q};
      end else begin : g_nopad
         assign mask_w = mask_q;
         assign pend_w = pend_q;
         assign serv_w = serv_q;
      end
   endgenerate

   assign poll_w = raw_found ? {1'b1, {(DATA_W-1-IDX_W){1'b0}}, raw_idx} : '0;

   always_comb begin
      if (reg_addr) begin
         reg_rdata = mask_w;
      end else begin
         unique case (rsel_q)
            RSEL_PENDING: reg_rdata = pend_w;
            RSEL_SERVICE: reg_rdata = serv_w;
            default:      reg_rdata = poll_w;
         endcase
      end
   end

   // ---------------- assertions ----------------
   assert_edge_capture_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

   assert_mask_load_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_port && !setup_busy) |=> (mask_q == $past(reg_wdata[NUM_IRQ-1:0])));

   assert_setup_keeps_mask_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_port && setup_busy) |=> $stable(mask_q));

   assert_eoi_all_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && dec.eoi_all && !int_ack) |=> (serv_q == '0));

   assert_masked_silent_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (live_req == '0) |-> !int_out);

   assert_ack_vector_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out) |=> vec_valid);

   assert_no_stray_vector_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      !(int_ack && int_out) |=> !vec_valid);

   assert_ack_moves_one_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out && !reg_wr) |=> ($countones(serv_q & ~$past(serv_q)) == 1));

endmodule

// File: tb/intc8_core_tb_top.sv
`timescale 1ns/1ps
module intc8_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [7:0] irq_lines = 8'h00;
   logic       int_ack = 1'b0;
   logic       int_out;
   logic       vec_valid;
   logic [7:0] vec_id;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // scoreboard queues: kind 0 rdata, 1 int_out, 2 vector, 3 vec_valid
   int         kind_q[$];
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   intc8_core #(.NUM_IRQ(8), .DATA_W(8)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_lines (irq_lines),
      .int_ack   (int_ack),
      .int_out   (int_out),
      .vec_valid (vec_valid),
      .vec_id    (vec_id)
   );

   // monitor: pops expectations and compares them away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (kind_q.size() > 0) begin
            automatic int         k = kind_q.pop_front();
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            automatic logic [7:0] a;
            case (k)
               0:       a = reg_rdata;
               1:       a = {7'b0, int_out};
               2:       a = vec_valid ? vec_id : 8'hEE;
               default: a = {7'b0, vec_valid};
            endcase
            total++;
            if (a !== e) begin
               bad++;
               $display("FAIL %s actual=0x%02h expected=0x%02h", t, a, e);
            end
         end
      end
   end

   task automatic push(input int k, input logic [7:0] e, input string t);
      kind_q.push_back(k);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic a, input logic [7:0] e, input string t);
      @(negedge clk);
      reg_addr = a;
      push(0, e, t);
   endtask

   task automatic out_chk(input logic e, input string t);
      @(negedge clk);
      push(1, {7'b0, e}, t);
   endtask

   task automatic pulse(input int line);
      @(negedge clk);
      irq_lines[line] = 1'b1;
      @(negedge clk);
      irq_lines[line] = 1'b0;
   endtask

   task automatic ack_chk(input logic [7:0] e, input string t);
      @(negedge clk);
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
      push(2, e, t);
   endtask

   task automatic ack_none(input string t);
      @(negedge clk);
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
      push(3, 8'h00, t);
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired before stimulus finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(1'b0, 8'h00, "R1 poll byte after reset");
      rd_chk(1'b1, 8'h00, "R1 mask after reset");
      out_chk(1'b0, "R1 int_out after reset");

      // R3/R4 full setup: cascade + final byte, base 0x45 -> 0x40
      wr(1'b0, 8'h11);
      wr(1'b1, 8'h45);
      wr(1'b1, 8'h04);
      wr(1'b1, 8'h01);
      rd_chk(1'b1, 8'h00, "R3 setup bytes leave mask");
      wr(1'b1, 8'hF0);
      rd_chk(1'b1, 8'hF0, "R6 mask read back");

      // R2/R8/R12 masked request
      pulse(5);
      rd_chk(1'b0, 8'h85, "R8 default poll shows masked line 5");
      out_chk(1'b0, "R12 masked line does not interrupt");
      wr(1'b0, 8'h0A);
      rd_chk(1'b0, 8'h20, "R7 pending select");
      pulse(2);
      rd_chk(1'b0, 8'h24, "R2 edge sets pending bit 2");
      out_chk(1'b1, "R12 unmasked line 2 interrupts");
      ack_chk(8'h42, "R13 vector base|2");
      wr(1'b0, 8'h0B);
      rd_chk(1'b0, 8'h04, "R13 line 2 in service");
      out_chk(1'b0, "R12 nothing outranks service");
      pulse(3);
      out_chk(1'b0, "R12 line 3 below in-service 2");
      pulse(0);
      out_chk(1'b1, "R12 line 0 nests over 2");
      ack_chk(8'h40, "R13 vector base|0");
      rd_chk(1'b0, 8'h05, "R13 lines 0 and 2 in service");

      // R10 specific clears
      wr(1'b0, 8'h60);
      rd_chk(1'b0, 8'h04, "R10 0x60 clears line 0");
      out_chk(1'b0, "R12 line 3 still below 2");
      wr(1'b0, 8'hE2);
      rd_chk(1'b0, 8'h00, "R10 0xE2 clears line 2");
      out_chk(1'b1, "R12 line 3 now eligible");
      wr(1'b0, 8'h0A);
      rd_chk(1'b0, 8'h28, "R7 pending lines 3 and 5");
      ack_chk(8'h43, "R13 vector base|3");

      // R11 ignored commands
      wr(1'b0, 8'h0B);
      wr(1'b0, 8'h68);
      wr(1'b0, 8'hC3);
      wr(1'b0, 8'h0D);
      rd_chk(1'b0, 8'h08, "R11 service and select unchanged");
      rd_chk(1'b1, 8'hF0, "R11 mask unchanged");
      wr(1'b0, 8'h0A);
      rd_chk(1'b0, 8'h20, "R11 pending unchanged");

      // R9 clear-all
      pulse(3);
      wr(1'b0, 8'h20);
      rd_chk(1'b0, 8'h20, "R9 pending bit 3 cleared with service");
      wr(1'b0, 8'h0B);
      rd_chk(1'b0, 8'h00, "R9 service empty");
      wr(1'b0, 8'h0A);
      wr(1'b0, 8'h25);
      rd_chk(1'b0, 8'h00, "R10 0x25 clears pending line 5");

      // R2 held line does not retrigger
      @(negedge clk);
      irq_lines[1] = 1'b1;
      out_chk(1'b1, "R2 line 1 captured");
      ack_chk(8'h41, "R13 vector base|1");
      wr(1'b0, 8'h20);
      rd_chk(1'b0, 8'h00, "R2 held line not re-latched");
      out_chk(1'b0, "R2 no interrupt from held line");
      @(negedge clk);
      irq_lines[1] = 1'b0;

      // R8 poll mode
      wr(1'b0, 8'h0C);
      rd_chk(1'b0, 8'h00, "R8 poll empty");
      pulse(6);
      pulse(4);
      rd_chk(1'b0, 8'h84, "R8 poll lowest pending is 4");
      out_chk(1'b0, "R12 lines 4,6 masked");

      // R6/R12 mask write re-evaluates output
      wr(1'b1, 8'h00);
      out_chk(1'b1, "R6 unmask raises int_out");
      wr(1'b1, 8'hFF);
      out_chk(1'b0, "R6 full mask drops int_out");
      ack_none("R13 ack ignored when int_out low");
      rd_chk(1'b0, 8'h84, "R13 pending untouched by ignored ack");

      // R5 abort setup
      wr(1'b0, 8'h13);
      wr(1'b0, 8'h0A);
      wr(1'b1, 8'h3C);
      rd_chk(1'b1, 8'h3C, "R5 abort then mask load");
      rd_chk(1'b0, 8'h50, "R5 aborting command executed");

      // R4 short setup: single, no final byte, level bit set
      wr(1'b0, 8'h1A);
      wr(1'b1, 8'h88);
      wr(1'b1, 8'h00);
      rd_chk(1'b1, 8'h00, "R4 setup ended after base byte");
      out_chk(1'b1, "R4 edge-captured lines still interrupt");
      ack_chk(8'h8C, "R4 new base 0x88 | 4");

      // R4 single with final byte
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h20);
      wr(1'b1, 8'h01);
      wr(1'b1, 8'h0F);
      rd_chk(1'b1, 8'h0F, "R4 final byte consumed then mask");
      out_chk(1'b0, "R12 line 6 below in-service 4");
      wr(1'b0, 8'h20);
      out_chk(1'b1, "R9 clear-all lets line 6 through");
      ack_chk(8'h26, "R13 vector 0x20 | 6");

      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule